// File: doc/BRIEF.md
# Cascaded BCD Programmable Divider

This block divides a stream of count-enable strobes by a three-digit decimal value from 1 to 999. It is a chain of decade down-counters. Each digit steps down through 9..0 and wraps to 9. Each time a digit steps out of 0 it passes one borrow to the next higher digit. A digit reports zero only when every digit above it is also zero. The zero report of the lowest digit therefore means that the whole counter reads 000. That single condition drives both the reload and the terminal pulse. The divide ratio is the decimal number read across the preset digits. For example, a preset of 263 divides by 263. It is not the product of the per-digit ratios.

A controller with three states sequences the counter:
- `ST_HALT` (after reset, or after a one-shot has finished): enables are ignored.
- `ST_DIV` (continuous division): the counter reloads each time it passes through zero.
- `ST_SHOT` (one-shot): the counter counts the preset number of enables once and then halts.

A `start` strobe loads the preset and picks the state from `oneshot`. The transitions are:
- HALT→DIV or HALT→SHOT on `start`.
- DIV→DIV or DIV→SHOT on `start`, which restarts the count.
- SHOT→HALT on the enable that brings the count to zero.

Top module: `bcd_cascade_divider`

## Requirements
- R1: While `rst` is high, the digits load the (limited) preset on each clock edge. After reset, `busy` and `term_pulse` are 0.
- R2: A `start` strobe loads the limited preset into `digits` on that edge. `busy` becomes 1 from the next cycle. An enable in the same cycle as `start` is not counted.
- R3: Any preset nibble above 9 is loaded as 9. For example, preset 12'h1F3 behaves as 193. All digits always hold a value from 0 to 9.
- R4: Each enabled step decrements the units digit. A digit at 0 wraps to 9 and borrows one from the digit above it. For example, 100 steps to 099 (hundreds in `digits[11:8]`, units in `digits[3:0]`).
- R5: In divider mode with preset P ≥ 1, `term_pulse` is high after exactly every P-th enable, counted from `start`, and `digits` reads 000 while it is high.
- R6: For P ≥ 2, `term_pulse` is exactly one clock cycle wide even when the enable stays high.
- R7: While running, a cycle without enable and without `start` leaves `digits` unchanged and gives `term_pulse` 0.
- R8: In one-shot mode, the P-th enable raises `term_pulse` for one cycle and drops `busy`. The digits then stay at 000 and further enables are ignored until the next `start`.
- R9: In divider mode, a preset of 000 keeps the digits at 000 and raises `term_pulse` after every enabled cycle.
- R10: While halted, enables leave `digits` unchanged and produce no `term_pulse`.
- R11: A `start` during a count abandons it and reloads the current preset.
- R12: In divider mode, a preset of 001 gives a terminal pulse after every enable (divide by 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cnt_en | input | 1 | Count enable strobe (the divided stream) |
| start | input | 1 | Load preset and begin counting |
| oneshot | input | 1 | Mode sampled at `start`: 1 = one-shot, 0 = divider |
| preset | input | 12 | Three BCD digits, hundreds in [11:8] |
| digits | output | 12 | Current count, three BCD digits |
| term_pulse | output | 1 | High in the cycle after the enable that reaches 000 |
| busy | output | 1 | High while in divider or one-shot counting |

## Verification
The in-line assertions cover the behaviours that hold on every cycle:
- every digit stays in BCD range;
- the digits hold without an enable, and hold while halted;
- the terminal pulse only ever appears at 000;
- `busy` can only fall together with a terminal pulse.

Other behaviours are sequences that only the bench scenarios can show: the exact P-enable period for several presets, the clamping of illegal nibbles, the borrow from 100 to 099, the one-shot halt, the restart in mid-count, and the degenerate presets 000 and 001.

// File: rtl/bcd_div_pkg.sv
package bcd_div_pkg;

    typedef enum logic [1:0] {
        ST_HALT = 2'd0,
        ST_DIV  = 2'd1,
        ST_SHOT = 2'd2
    } div_state_e;

    function automatic logic [3:0] clamp_digit(input logic [3:0] d);
        return (d > 4'd9) ? 4'd9 : d;
    endfunction

endpackage

// File: rtl/bcd_decade.sv
module bcd_decade (
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  logic [3:0] load_val,
    input  logic       step_in,
    input  logic       cf_in,
    output logic [3:0] digit,
    output logic       zero_out,
    output logic       borrow_out
);
    logic at_zero;

    assign at_zero    = (digit == 4'd0);
    assign zero_out   = at_zero & cf_in;
    assign borrow_out = step_in & at_zero;

    always_ff @(posedge clk) begin
        if (load) begin
            digit <= load_val;
        end else if (step_in) begin
            digit <= at_zero ? 4'd9 : digit - 4'd1;
        end
    end

    AST_DIGIT_RANGE: assert property (@(posedge clk) disable iff (rst)
        digit <= 4'd9);                                            // R3

    AST_DIGIT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!load && !step_in) |=> $stable(digit));                   // R7

endmodule

// File: rtl/bcd_div_ctrl.sv
module bcd_div_ctrl
    import bcd_div_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic oneshot,
    input  logic cnt_en,
    input  logic all_zero,
    input  logic will_zero,
    output logic dig_load,
    output logic sel_preset,
    output logic dig_step,
    output logic term_q,
    output logic busy
);
    div_state_e state, state_nx;
    logic       live;
    logic       hit;

    assign live = cnt_en && !start && (state != ST_HALT);
    assign hit  = live && will_zero;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_HALT;
            term_q <= 1'b0;
        end else begin
            state  <= state_nx;
            term_q <= hit;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_HALT: if (start) state_nx = oneshot ? ST_SHOT : ST_DIV;
            ST_DIV:  if (start) state_nx = oneshot ? ST_SHOT : ST_DIV;
            ST_SHOT: begin
                if (start)    state_nx = oneshot ? ST_SHOT : ST_DIV;
                else if (hit) state_nx = ST_HALT;
            end
            default: state_nx = ST_HALT;
        endcase
    end

    always_comb begin
        busy       = (state != ST_HALT);
        sel_preset = rst || start;
        dig_load   = rst || start || (live && all_zero && (state == ST_DIV));
        dig_step   = live && !all_zero;
    end

    AST_BUSY_DROP: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> term_q);                                   // R8

endmodule

// File: rtl/bcd_cascade_divider.sv
module bcd_cascade_divider #(
    parameter int NDIG = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cnt_en,
    input  logic              start,
    input  logic              oneshot,
    input  logic [4*NDIG-1:0] preset,
    output logic [4*NDIG-1:0] digits,
    output logic              term_pulse,
    output logic              busy
);
    import bcd_div_pkg::*;

    localparam int W = 4 * NDIG;

    logic [W-1:0]  pre_lim;
    logic [W-1:0]  pre_dec;
    logic [W-1:0]  ld_val;
    logic [NDIG:0] cf;
    logic [NDIG:0] brw;
    logic          dig_load, sel_preset, dig_step;
    logic          all_zero, at_one, reload_zero, will_zero;

    function automatic logic [W-1:0] bcd_minus_one(input logic [W-1:0] v);
        logic [W-1:0] r;
        logic         b;
        r = v;
        b = 1'b1;
        for (int i = 0; i < NDIG; i++) begin
            if (b) begin
                if (v[4*i +: 4] == 4'd0) r[4*i +: 4] = 4'd9;
                else begin
                    r[4*i +: 4] = v[4*i +: 4] - 4'd1;
                    b = 1'b0;
                end
            end
        end
        return b ? '0 : r;
    endfunction

    generate
        for (genvar g = 0; g < NDIG; g++) begin : g_lim
            assign pre_lim[4*g +: 4] = clamp_digit(preset[4*g +: 4]);
        end
    endgenerate

    assign pre_dec     = bcd_minus_one(pre_lim);
    assign ld_val      = sel_preset ? pre_lim : pre_dec;
    assign cf[NDIG]    = 1'b1;
    assign brw[0]      = dig_step;
    assign all_zero    = cf[0];
    assign at_one      = cf[1] && (digits[3:0] == 4'd1);
    assign reload_zero = (pre_dec == '0);
    assign will_zero   = all_zero ? reload_zero : at_one;

    generate
        for (genvar g = 0; g < NDIG; g++) begin : g_dec
            bcd_decade u_dec (
                .clk       (clk),
                .rst       (rst),
                .load      (dig_load),
                .load_val  (ld_val[4*g +: 4]),
                .step_in   (brw[g]),
                .cf_in     (cf[g+1]),
                .digit     (digits[4*g +: 4]),
                .zero_out  (cf[g]),
                .borrow_out(brw[g+1])
            );
        end
    endgenerate

    bcd_div_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .oneshot   (oneshot),
        .cnt_en    (cnt_en),
        .all_zero  (all_zero),
        .will_zero (will_zero),
        .dig_load  (dig_load),
        .sel_preset(sel_preset),
        .dig_step  (dig_step),
        .term_q    (term_pulse),
        .busy      (busy)
    );

    AST_TERM_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
        term_pulse |-> (digits == '0));                            // R5

    AST_HOLD_NO_EN: assert property (@(posedge clk) disable iff (rst)
        (busy && !cnt_en && !start) |=> ($stable(digits) && !term_pulse)); // R7

    AST_HALT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> ($stable(digits) && !term_pulse));   // R10

endmodule

// File: tb/bcd_cascade_divider_bench.sv
module bcd_cascade_divider_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cnt_en = 1'b0;
    logic        start = 1'b0;
    logic        oneshot = 1'b0;
    logic [11:0] preset = 12'h263;
    logic [11:0] digits;
    logic        term_pulse;
    logic        busy;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // {preset, expected divide ratio}
    localparam logic [21:0] VEC [7] = '{
        {12'h263, 10'd263},
        {12'h004, 10'd4},
        {12'h001, 10'd1},
        {12'h010, 10'd10},
        {12'h999, 10'd999},
        {12'h1F3, 10'd193},
        {12'h0A0, 10'd90}
    };

    always #2.5 clk = ~clk;

    bcd_cascade_divider u_bcd_cascade_divider (
        .clk       (clk),
        .rst       (rst),
        .cnt_en    (cnt_en),
        .start     (start),
        .oneshot   (oneshot),
        .preset    (preset),
        .digits    (digits),
        .term_pulse(term_pulse),
        .busy      (busy)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    task automatic do_start(input logic [11:0] p, input logic os);
        preset  = p;
        oneshot = os;
        start   = 1'b1;
        cnt_en  = 1'b1;
        tick();
        start   = 1'b0;
        cnt_en  = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0h expected %0h", 1, 0);
        report();
    end

    initial begin
        tick();
        tick();
        rst = 1'b0;
        // R1: reset state
        chk(digits == 12'h263, "R1 digits", digits, 12'h263);
        chk(busy == 1'b0, "R1 busy", busy, 0);
        chk(term_pulse == 1'b0, "R1 term", term_pulse, 0);

        // R10: enables ignored while halted
        cnt_en = 1'b1;
        for (int i = 0; i < 3; i++) begin
            tick();
            chk(digits == 12'h263 && !term_pulse, "R10 halt hold", digits, 12'h263);
        end
        cnt_en = 1'b0;

        // R5 R12 R3: table of divide ratios
        foreach (VEC[k]) begin
            logic [11:0] p;
            int          r;
            p = VEC[k][21:10];
            r = int'(VEC[k][9:0]);
            do_start(p, 1'b0);
            chk(busy == 1'b1, "R2 busy after start", busy, 1);
            cnt_en = 1'b1;
            for (int n = 1; n <= 2 * r; n++) begin
                bit exp_t;
                tick();
                exp_t = (n % r) == 0;
                if (r == 1) chk(term_pulse == 1'b1, "R12 divide by one", term_pulse, 1);
                else chk(term_pulse == exp_t, "R5 term timing", term_pulse, exp_t);
                if (exp_t) chk(digits == 12'h000, "R5 zero at term", digits, 0);
            end
            cnt_en = 1'b0;
            tick();
            chk(term_pulse == 1'b0, "R6 single cycle", term_pulse, 0);
        end

        // R2 R3: start loads the limited preset, enable in the start cycle is ignored
        do_start(12'hFAB, 1'b0);
        chk(digits == 12'h999, "R3 clamp", digits, 12'h999);
        do_start(12'h263, 1'b0);
        chk(digits == 12'h263, "R2 load", digits, 12'h263);

        // R4: borrow across two digits
        do_start(12'h100, 1'b0);
        cnt_en = 1'b1;
        tick();
        cnt_en = 1'b0;
        chk(digits == 12'h099, "R4 borrow", digits, 12'h099);
        // R7: hold without enable
        tick();
        tick();
        chk(digits == 12'h099 && !term_pulse, "R7 hold", digits, 12'h099);

        // R11: restart in mid-count
        do_start(12'h050, 1'b0);
        chk(digits == 12'h050, "R11 restart", digits, 12'h050);

        // R8: one-shot
        do_start(12'h005, 1'b1);
        cnt_en = 1'b1;
        for (int n = 1; n <= 5; n++) begin
            tick();
            chk(term_pulse == (n == 5), "R8 shot term", term_pulse, n == 5);
        end
        chk(busy == 1'b0, "R8 busy drop", busy, 0);
        for (int n = 0; n < 3; n++) tick();
        chk(digits == 12'h000 && !term_pulse && !busy, "R8 halted", digits, 0);
        cnt_en = 1'b0;

        // R9: zero preset in divider mode
        do_start(12'h000, 1'b0);
        cnt_en = 1'b1;
        for (int n = 0; n < 3; n++) begin
            tick();
            chk(term_pulse == 1'b1 && digits == 12'h000, "R9 zero preset", term_pulse, 1);
        end
        cnt_en = 1'b0;
        tick();
        chk(term_pulse == 1'b0, "R9 no enable", term_pulse, 0);

        // R1: reset in mid-run
        do_start(12'h300, 1'b0);
        preset = 12'h042;
        rst = 1'b1;
        tick();
        rst = 1'b0;
        chk(digits == 12'h042 && !busy, "R1 reset reload", digits, 12'h042);

        report();
    end
endmodule